// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This unit adds two signed numbers held in sign-magnitude form and returns their sum in the same form. Each operand arrives as an unsigned magnitude of `W` bits with its own sign control, where 0 means positive and 1 means negative. The output is a sign bit and a magnitude that is one bit wider, so the sum of two full-scale operands still fits. Choosing the two sign controls gives the four operations x+y, -x+y, x-y and -x-y with no separate opcode.

Inside, a first ripple adder works on the operands. When the signs differ, it inverts the operand marked negative and sets its carry-in, so that it performs a two's-complement subtraction. A second ripple adder adds an inverted copy of that sum to a 1 at bit 0. It does this only when the difference came out negative, and so turns it back into a positive magnitude. The unit has no clock and no state. Its outputs follow its inputs through logic alone.

Top module: `smas_unit`

## Requirements
- R1: When both sign controls are equal, `res_mag` equals `x_mag + y_mag` as a W+1 bit value, and `res_neg` equals the common sign control whenever that magnitude is non-zero.
- R2: When the sign controls differ, `res_mag` equals the absolute difference of `x_mag` and `y_mag`, and `res_mag[W]` is 0.
- R3: When the sign controls differ and the magnitudes are unequal, `res_neg` equals the sign control of the operand with the larger magnitude.
- R4: A zero result is always reported as `res_neg` = 0 and `res_mag` = 0. Negative zero never appears, including for two negative zero operands.
- R5: `res_mag[W]` is 1 exactly when the result magnitude exceeds 2^W-1. For W=4, +8 plus +8 gives `res_neg`=0 and `res_mag`=5'b10000.
- R6: With the sign controls encoded as 0 for positive and 1 for negative, the value (`res_neg` ? -1 : 1) * `res_mag` equals the signed integer sum of the two operands, for all four sign combinations.
- R7: The outputs depend only on the present inputs. A change of inputs is reflected without any clock edge.
- R8: For W=4 the following results hold: (-8)+(-8) gives sign 1 and magnitude 16. (+7)+(+5) gives sign 0 and magnitude 12. (-7)+(-5) gives sign 1 and magnitude 12. (-8)+(+3) gives sign 1 and magnitude 5. (+8)+(-3) gives sign 0 and magnitude 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_mag | input | W | Magnitude of the first operand |
| x_neg | input | 1 | Sign control of the first operand, 1 = negative |
| y_mag | input | W | Magnitude of the second operand |
| y_neg | input | 1 | Sign control of the second operand, 1 = negative |
| res_neg | output | 1 | Sign of the result, 1 = negative, never set for zero |
| res_mag | output | W+1 | Magnitude of the result, top bit set above 2^W-1 |

## Verification
The checker evaluates its immediate assertions whenever the ports change. It assumes that all four inputs carry known values, and it skips any evaluation while an input is still unknown. The bench therefore drives every input to a defined value before its first sample and never releases them. Within that constraint every input pattern is legal. The bench sweeps all 2^(2W+2) combinations, so the assertions see the full input space, including both forms of zero and both full-scale extremes.

// File: rtl/smas_pkg.sv
package smas_pkg;

    localparam int SMAS_DEFAULT_W = 4;

    // Which arithmetic path the first stage takes.
    typedef enum logic {
        PATH_SUM  = 1'b0,   // signs agree: plain magnitude addition
        PATH_DIFF = 1'b1    // signs differ: two's-complement subtraction
    } path_e;

    // Control word of the first stage, derived from the sign inputs only.
    typedef struct packed {
        path_e path;
        logic  inv_x;   // complement x in stage one
        logic  inv_y;   // complement y in stage one
        logic  cin;     // carry injected into stage one
    } stage1_ctrl_t;

endpackage

// File: rtl/smas_cond_invert.sv
module smas_cond_invert #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);

    // One XOR per bit acts as a controlled inverter.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] ^ inv;
    end

endmodule

// File: rtl/smas_ripple_add.sv
module smas_ripple_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] carry;

    assign carry[0] = cin;

    // Chain of full adders, one per bit.
    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p          = a[i] ^ b[i];
        assign sum[i]     = p ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (p & carry[i]);
    end

    assign cout = carry[W];

endmodule

// File: rtl/smas_unit.sv
module smas_unit
    import smas_pkg::*;
#(
    parameter int W = SMAS_DEFAULT_W
) (
    input  logic [W-1:0] x_mag,
    input  logic         x_neg,
    input  logic [W-1:0] y_mag,
    input  logic         y_neg,
    output logic         res_neg,
    output logic [W:0]   res_mag
);

    localparam logic [W-1:0] ZERO_W = '0;

    stage1_ctrl_t ctrl_d;

    logic [W-1:0] x_op, y_op;
    logic [W-1:0] s1_sum;
    logic         s1_cout;
    logic         fix_d;       // intermediate is negative: re-complement it
    logic [W-1:0] s2_b;
    logic [W-1:0] s2_a;
    logic [W-1:0] s2_sum;
    logic         unused_s2_cout;
    logic         mag_top_d;
    logic         nonzero_d;

    // Stage-one control from the two sign controls.
    always_comb begin
        ctrl_d.path  = (x_neg ^ y_neg) ? PATH_DIFF : PATH_SUM;
        ctrl_d.inv_x = (ctrl_d.path == PATH_DIFF) & x_neg;
        ctrl_d.inv_y = (ctrl_d.path == PATH_DIFF) & y_neg;
        ctrl_d.cin   = (ctrl_d.path == PATH_DIFF);
    end

    smas_cond_invert #(.W(W)) u_inv_x (
        .din  (x_mag),
        .inv  (ctrl_d.inv_x),
        .dout (x_op)
    );

    smas_cond_invert #(.W(W)) u_inv_y (
        .din  (y_mag),
        .inv  (ctrl_d.inv_y),
        .dout (y_op)
    );

    smas_ripple_add #(.W(W)) u_add_first (
        .a    (x_op),
        .b    (y_op),
        .cin  (ctrl_d.cin),
        .sum  (s1_sum),
        .cout (s1_cout)
    );

    // On the difference path a missing carry means a borrow: the
    // positive operand was the smaller one, so the sum is negative.
    always_comb begin
        fix_d = (ctrl_d.path == PATH_DIFF) & ~s1_cout;
        s2_a  = {ZERO_W[W-1:1], fix_d};
    end

    smas_cond_invert #(.W(W)) u_inv_sum (
        .din  (s1_sum),
        .inv  (fix_d),
        .dout (s2_b)
    );

    smas_ripple_add #(.W(W)) u_add_second (
        .a    (s2_a),
        .b    (s2_b),
        .cin  (1'b0),
        .sum  (s2_sum),
        .cout (unused_s2_cout)
    );

    // Assemble sign and magnitude.
    always_comb begin
        mag_top_d = (ctrl_d.path == PATH_SUM) & s1_cout;
        nonzero_d = mag_top_d | (|s2_sum);
        res_mag   = {mag_top_d, s2_sum};
        if (ctrl_d.path == PATH_DIFF) begin
            res_neg = fix_d;
        end else begin
            res_neg = x_neg & nonzero_d;
        end
    end

endmodule

// File: rtl/smas_checks.sv
module smas_checks #(
    parameter int W = 4
) (
    input logic [W-1:0] x_mag,
    input logic         x_neg,
    input logic [W-1:0] y_mag,
    input logic         y_neg,
    input logic         res_neg,
    input logic [W:0]   res_mag
);

    logic [W:0] xe, ye;
    logic       known;

    always_comb begin
        xe    = {1'b0, x_mag};
        ye    = {1'b0, y_mag};
        known = !$isunknown({x_mag, x_neg, y_mag, y_neg, res_neg, res_mag});
        if (known) begin
            // R1: equal signs add magnitudes and keep the sign
            p_same_sum_r1: assert ((x_neg != y_neg) || (res_mag == xe + ye));
            p_same_sign_r1: assert ((x_neg != y_neg) || (res_mag == '0) || (res_neg == x_neg));
            // R2: opposite signs give the difference, no top bit
            p_diff_mag_r2: assert ((x_neg == y_neg) || (res_mag + ((xe < ye) ? xe : ye) == ((xe < ye) ? ye : xe)));
            p_diff_top_r2: assert ((x_neg == y_neg) || !res_mag[W]);
            // R3: sign follows the larger operand
            p_diff_sign_r3: assert ((x_neg == y_neg) || (xe == ye) || (res_neg == ((xe > ye) ? x_neg : y_neg)));
            // R4: never negative zero
            p_no_neg_zero_r4: assert ((res_mag != '0) || !res_neg);
            // R5: top bit only when operands could exceed one word
            p_top_bit_r5: assert (!res_mag[W] || (xe + ye > {1'b0, {W{1'b1}}}));
        end
    end

endmodule

bind smas_unit smas_checks #(.W(W)) u_smas_checks (
    .x_mag   (x_mag),
    .x_neg   (x_neg),
    .y_mag   (y_mag),
    .y_neg   (y_neg),
    .res_neg (res_neg),
    .res_mag (res_mag)
);

// File: tb/smas_unit_bench.sv
`timescale 1ns/1ps
module smas_unit_bench;

    localparam int W  = 4;
    localparam int NV = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x_mag = '0;
    logic         x_neg = 1'b0;
    logic [W-1:0] y_mag = '0;
    logic         y_neg = 1'b0;
    logic         res_neg;
    logic [W:0]   res_mag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    smas_unit #(.W(W)) u_smas_unit (
        .x_mag   (x_mag),
        .x_neg   (x_neg),
        .y_mag   (y_mag),
        .y_neg   (y_neg),
        .res_neg (res_neg),
        .res_mag (res_mag)
    );

    // {x_neg, x_mag, y_neg, y_mag, exp_neg, exp_mag}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 4'd8,  1'b0, 4'd8,  1'b0, 5'd16},  // R5 +8 + +8
        {1'b1, 4'd8,  1'b1, 4'd8,  1'b1, 5'd16},  // R8
        {1'b0, 4'd7,  1'b0, 4'd5,  1'b0, 5'd12},  // R8
        {1'b1, 4'd7,  1'b1, 4'd5,  1'b1, 5'd12},  // R8
        {1'b1, 4'd8,  1'b0, 4'd3,  1'b1, 5'd5},   // R8
        {1'b0, 4'd8,  1'b1, 4'd3,  1'b0, 5'd5},   // R8
        {1'b0, 4'd6,  1'b1, 4'd6,  1'b0, 5'd0},   // R4
        {1'b1, 4'd0,  1'b1, 4'd0,  1'b0, 5'd0},   // R4
        {1'b1, 4'd15, 1'b1, 4'd15, 1'b1, 5'd30},  // R5
        {1'b1, 4'd3,  1'b0, 4'd9,  1'b0, 5'd6}    // R3
    };

    task automatic check(input string tag, input logic en, input logic [W:0] em);
        n_checks++;
        if (res_neg !== en || res_mag !== em) begin
            n_fail++;
            $display("FAIL %s: x=%0s%0d y=%0s%0d got neg=%0b mag=%0d expected neg=%0b mag=%0d",
                     tag, x_neg ? "-" : "+", x_mag, y_neg ? "-" : "+", y_mag,
                     res_neg, res_mag, en, em);
        end
    endtask

    task automatic apply(input logic xn, input logic [W-1:0] xm,
                         input logic yn, input logic [W-1:0] ym);
        @(posedge clk);
        x_neg = xn; x_mag = xm; y_neg = yn; y_mag = ym;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state with all-zero inputs: positive zero (R4)
        @(negedge clk);
        check("R4", 1'b0, '0);

        // Table of known results (R8, R5, R4, R3)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][15], VEC[i][14:11], VEC[i][10], VEC[i][9:6]);
            check("R8", VEC[i][5], VEC[i][4:0]);
        end

        // R7: inputs change with no clock edge between drive and sample
        @(negedge clk);
        x_neg = 1'b0; x_mag = 4'd2; y_neg = 1'b1; y_mag = 4'd11;
        #1;
        check("R7", 1'b1, 5'd9);
        x_mag = 4'd13;
        #1;
        check("R7", 1'b0, 5'd2);

        // Exhaustive sweep against the signed integer sum (R6, R1, R2)
        for (int i = 0; i < (1 << (2*W+2)); i++) begin
            logic       xn, yn, en;
            logic [W-1:0] xm, ym;
            int         s;
            logic [W:0] em;
            xm = i[W-1:0];
            xn = i[W];
            ym = i[2*W:W+1];
            yn = i[2*W+1];
            apply(xn, xm, yn, ym);
            s  = (xn ? -int'(xm) : int'(xm)) + (yn ? -int'(ym) : int'(ym));
            en = (s < 0);
            em = (s < 0) ? (W+1)'(-s) : (W+1)'(s);
            if (xn == yn) check("R6 R1", en, em);
            else          check("R6 R2", en, em);
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule